// File: doc/BRIEF.md
# Multi-Channel DMA Channel Enable Control Register

This block is the shared run-control word of a multi-channel DMA controller. For every channel it keeps three control bits: run enable, suspend and abort. Each control bit has a companion write-enable bit in the same 64-bit write word. A bus write changes only the control bits whose companion bit is set, so software can start, pause, resume or kill one channel without a read-modify-write that could disturb the others.

The stored bits drive the channel engines directly. Each engine reports back three things: a completion pulse, an abort-complete pulse and a level that says it has drained while suspended. A completion or abort-complete pulse clears that channel's control bits after one cycle. A request to clear the enable bit waits until the engine signals that it has drained. Each channel also has a decoded state output (idle, suspended or active), and the whole word can be read back on the bus.

The channel count `N_CH` is a parameter with a maximum of 8. The bit positions below hold for any count.

Top module: `chan_ctl_reg`

## Requirements
- R1: In the write and readback word, channel n uses these bits: enable at bit n with its write-enable at 8+n, suspend at 16+n with its write-enable at 24+n, and abort at 32+n with its write-enable at 40+n.
- R2: A write changes a control bit only if the paired write-enable bit is 1 in the same write. Every other control bit of every channel keeps its value.
- R3: Readback returns 0 in all write-enable positions and in every bit that no channel uses.
- R4: `ch_state_o[2n+1:2n]` is 2 (active) when the enable bit is set, 1 (suspended) when the suspend bit is set and enable is clear, and 0 (idle) otherwise.
- R5: A write with suspend=0 and its write-enable=1 clears the suspend bit (resume).
- R6: A write that clears the enable bit of an enabled channel does not clear it at once. The bit stays set until the first rising edge after that write at which `eng_susp_ack[n]` is high. It then clears, together with the abort bit. Without that acknowledge the bit stays set.
- R7: If `eng_done[n]` or `eng_abort_done[n]` is high at rising edge k, that channel's enable, suspend and abort bits are still unchanged by it after edge k and are all 0 after edge k+1.
- R8: An abort write (abort=1 with its write-enable) takes effect only while the enable bit is set and is otherwise ignored. The abort bit is never set while enable is clear.
- R9: Within one write to one channel, setting abort takes priority over suspend and enable, and setting suspend takes priority over enable. The lower-priority fields of that channel in that write are discarded.
- R10: `ch_en_o`, `ch_susp_o` and `ch_abort_o` mirror the stored bits. Reset (synchronous, active high) clears all bits, the read data and the outputs.
- R11: Read data is registered. It appears after the edge that samples `bus_rd` and shows the bits as they were before any write applied at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 64 | Write word: control bits and write-enable bits |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 64 | Registered readback word |
| eng_done | input | N_CH | Per-channel transfer-complete pulse |
| eng_abort_done | input | N_CH | Per-channel abort-complete pulse |
| eng_susp_ack | input | N_CH | Per-channel level: engine suspended and drained |
| ch_en_o | output | N_CH | Per-channel run enable to the engines |
| ch_susp_o | output | N_CH | Per-channel suspend request to the engines |
| ch_abort_o | output | N_CH | Per-channel abort request to the engines |
| ch_state_o | output | 2*N_CH | Per-channel state: 0 idle, 1 suspended, 2 active |

## Verification
The main sweep covers every channel. For each channel it applies all 64 combinations of the six enable/suspend/abort data and write-enable bits, from each of the four starting states built from enable and suspend. This separates the write-enable gating from the priority between abort, suspend and enable. It also exposes writes to a field that should have been ignored. In each write, the data bits of the other channels are set while their write-enable bits stay clear, so any crosstalk between channels shows up in the readback. Directed sequences cover the rest: the one-cycle delay on completion and abort-complete, the disable that waits for the drain acknowledge and then the resume, an abort on an idle channel, and a read issued in the same cycle as a write.

// File: rtl/chctl_pkg.sv
package chctl_pkg;
  localparam int WORD_W    = 64;
  localparam int MAX_CH    = 8;
  localparam int EN_POS    = 0;
  localparam int EN_WE_POS = 8;
  localparam int SU_POS    = 16;
  localparam int SU_WE_POS = 24;
  localparam int AB_POS    = 32;
  localparam int AB_WE_POS = 40;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SUSP   = 2'd1,
    ST_ACTIVE = 2'd2
  } chan_state_e;

  typedef struct packed {
    logic en_d;
    logic en_we;
    logic su_d;
    logic su_we;
    logic ab_d;
    logic ab_we;
  } ctl_req_t;
endpackage

// File: rtl/chctl_field_split.sv
module chctl_field_split
  import chctl_pkg::*;
#(
  parameter int N_CH = 8
) (
  input  logic [WORD_W-1:0]   wdata,
  output ctl_req_t [N_CH-1:0] req
);
  for (genvar n = 0; n < N_CH; n++) begin : g_split
    assign req[n].en_d  = wdata[EN_POS + n];
    assign req[n].en_we = wdata[EN_WE_POS + n];
    assign req[n].su_d  = wdata[SU_POS + n];
    assign req[n].su_we = wdata[SU_WE_POS + n];
    assign req[n].ab_d  = wdata[AB_POS + n];
    assign req[n].ab_we = wdata[AB_WE_POS + n];
  end
endmodule

// File: rtl/chctl_slice.sv
module chctl_slice
  import chctl_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wr_i,
  input  ctl_req_t req_i,
  input  logic     done_i,
  input  logic     abdone_i,
  input  logic     sack_i,
  output logic     en_q,
  output logic     su_q,
  output logic     ab_q
);
  logic fin_q;
  logic pend_q;
  logic drain;
  logic ab_set;
  logic su_set;

  // drain completes a pending disable; abort may not be set in that cycle
  assign drain  = pend_q & sack_i;
  assign ab_set = req_i.ab_we & req_i.ab_d & en_q & ~drain;
  assign su_set = req_i.su_we & req_i.su_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      fin_q  <= 1'b0;
      pend_q <= 1'b0;
      en_q   <= 1'b0;
      su_q   <= 1'b0;
      ab_q   <= 1'b0;
    end else begin
      fin_q <= done_i | abdone_i;
      if (fin_q) begin
        en_q   <= 1'b0;
        su_q   <= 1'b0;
        ab_q   <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        if (drain) begin
          en_q   <= 1'b0;
          ab_q   <= 1'b0;
          pend_q <= 1'b0;
        end
        if (wr_i) begin
          if (ab_set) begin
            ab_q <= 1'b1;
          end else if (su_set) begin
            su_q <= 1'b1;
          end else begin
            if (req_i.su_we) su_q <= 1'b0;
            if (req_i.ab_we && !req_i.ab_d) ab_q <= 1'b0;
            if (req_i.en_we) begin
              if (req_i.en_d) begin
                en_q   <= 1'b1;
                pend_q <= 1'b0;
              end else if (en_q) begin
                pend_q <= 1'b1;
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/chctl_readback.sv
module chctl_readback
  import chctl_pkg::*;
#(
  parameter int N_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  logic [N_CH-1:0]   en_i,
  input  logic [N_CH-1:0]   su_i,
  input  logic [N_CH-1:0]   ab_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] word;

  always_comb begin
    word = '0;
    for (int n = 0; n < N_CH; n++) begin
      word[EN_POS + n] = en_i[n];
      word[SU_POS + n] = su_i[n];
      word[AB_POS + n] = ab_i[n];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_o <= '0;
    else if (rd_i) rdata_o <= word;
  end
endmodule

// File: rtl/chan_ctl_reg.sv
module chan_ctl_reg
  import chctl_pkg::*;
#(
  parameter int N_CH = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic [63:0]         bus_wdata,
  input  logic                bus_rd,
  output logic [63:0]         bus_rdata,
  input  logic [N_CH-1:0]     eng_done,
  input  logic [N_CH-1:0]     eng_abort_done,
  input  logic [N_CH-1:0]     eng_susp_ack,
  output logic [N_CH-1:0]     ch_en_o,
  output logic [N_CH-1:0]     ch_susp_o,
  output logic [N_CH-1:0]     ch_abort_o,
  output logic [2*N_CH-1:0]   ch_state_o
);
  ctl_req_t [N_CH-1:0] req;

  chctl_field_split #(.N_CH(N_CH)) u_split (
    .wdata (bus_wdata),
    .req   (req)
  );

  for (genvar n = 0; n < N_CH; n++) begin : g_ch
    chan_state_e st;

    chctl_slice u_slice (
      .clk      (clk),
      .rst      (rst),
      .wr_i     (bus_wr),
      .req_i    (req[n]),
      .done_i   (eng_done[n]),
      .abdone_i (eng_abort_done[n]),
      .sack_i   (eng_susp_ack[n]),
      .en_q     (ch_en_o[n]),
      .su_q     (ch_susp_o[n]),
      .ab_q     (ch_abort_o[n])
    );

    always_comb begin
      if (ch_en_o[n])        st = ST_ACTIVE;
      else if (ch_susp_o[n]) st = ST_SUSP;
      else                   st = ST_IDLE;
    end
    assign ch_state_o[2*n +: 2] = st;
  end

  chctl_readback #(.N_CH(N_CH)) u_rb (
    .clk     (clk),
    .rst     (rst),
    .rd_i    (bus_rd),
    .en_i    (ch_en_o),
    .su_i    (ch_susp_o),
    .ab_i    (ch_abort_o),
    .rdata_o (bus_rdata)
  );
endmodule

// File: rtl/chan_ctl_chk.sv
module chan_ctl_chk
  import chctl_pkg::*;
#(
  parameter int N_CH = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [63:0]       bus_wdata,
  input logic              bus_rd,
  input logic [63:0]       bus_rdata,
  input logic [N_CH-1:0]   eng_done,
  input logic [N_CH-1:0]   eng_abort_done,
  input logic [N_CH-1:0]   eng_susp_ack,
  input logic [N_CH-1:0]   ch_en_o,
  input logic [N_CH-1:0]   ch_susp_o,
  input logic [N_CH-1:0]   ch_abort_o,
  input logic [2*N_CH-1:0] ch_state_o
);
  initial a_r1_ch_count: assert (N_CH >= 1 && N_CH <= MAX_CH);

  // R2: without enable write-enables, no acknowledge and no completion, enables hold
  a_r2_en_needs_we: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_wdata[EN_WE_POS +: N_CH] == '0 && eng_susp_ack == '0 &&
     $past(eng_done | eng_abort_done) == '0) |=> ch_en_o == $past(ch_en_o));

  for (genvar n = 0; n < N_CH; n++) begin : g_chk
    // R7: completion at edge k leaves the channel cleared after edge k+1
    a_r7_fin_clears: assert property (@(posedge clk) disable iff (rst)
      $past(eng_done[n] | eng_abort_done[n], 2) |-> !ch_en_o[n] && !ch_abort_o[n]);

    // R8: abort only while enabled
    a_r8_abort_needs_en: assert property (@(posedge clk) disable iff (rst)
      ch_abort_o[n] |-> ch_en_o[n]);

    // R9: suspend set wins over a new enable in the same write
    a_r9_susp_over_en: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && !ch_en_o[n] && bus_wdata[SU_WE_POS + n] && bus_wdata[SU_POS + n] &&
       bus_wdata[EN_WE_POS + n] && bus_wdata[EN_POS + n]) |=> !ch_en_o[n]);

    // R6: an enabled channel stays enabled without write, acknowledge or completion
    a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
      (ch_en_o[n] && !bus_wr && !eng_susp_ack[n] && !$past(eng_done[n] | eng_abort_done[n]))
      |=> ch_en_o[n]);
  end
endmodule

bind chan_ctl_reg chan_ctl_chk #(.N_CH(N_CH)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .bus_wr         (bus_wr),
  .bus_wdata      (bus_wdata),
  .bus_rd         (bus_rd),
  .bus_rdata      (bus_rdata),
  .eng_done       (eng_done),
  .eng_abort_done (eng_abort_done),
  .eng_susp_ack   (eng_susp_ack),
  .ch_en_o        (ch_en_o),
  .ch_susp_o      (ch_susp_o),
  .ch_abort_o     (ch_abort_o),
  .ch_state_o     (ch_state_o)
);

// File: tb/chan_ctl_reg_tb_top.sv
`timescale 1ns/1ps
module chan_ctl_reg_tb_top;
  localparam int N = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic [63:0]   bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [63:0]   bus_rdata;
  logic [N-1:0]  eng_done = '0;
  logic [N-1:0]  eng_abort_done = '0;
  logic [N-1:0]  eng_susp_ack = '0;
  logic [N-1:0]  ch_en_o, ch_susp_o, ch_abort_o;
  logic [2*N-1:0] ch_state_o;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  chan_ctl_reg #(.N_CH(N)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .eng_done(eng_done),
    .eng_abort_done(eng_abort_done), .eng_susp_ack(eng_susp_ack),
    .ch_en_o(ch_en_o), .ch_susp_o(ch_susp_o), .ch_abort_o(ch_abort_o),
    .ch_state_o(ch_state_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [63:0] d);
    @(negedge clk);
    bus_wr = 1'b1;
    bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic rd(output logic [63:0] d);
    @(negedge clk);
    bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic finish_ch(input int n);
    @(negedge clk);
    eng_done[n] = 1'b1;
    @(negedge clk);
    eng_done[n] = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [63:0] ctl(input int n, input bit en_d, en_we, su_d, su_we, ab_d, ab_we);
    logic [63:0] w = '0;
    w[n] = en_d; w[8+n] = en_we; w[16+n] = su_d;
    w[24+n] = su_we; w[32+n] = ab_d; w[40+n] = ab_we;
    return w;
  endfunction

  function automatic logic [63:0] word_of(input int n, input bit en, su, ab);
    logic [63:0] w = '0;
    w[n] = en; w[16+n] = su; w[32+n] = ab;
    return w;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 / R3 reset state
    rd(r);
    chk("R10 reset readback", r, 64'h0);
    chk("R10 reset outputs", {ch_en_o, ch_susp_o, ch_abort_o}, '0);
    chk("R4 reset state idle", ch_state_o, '0);

    // R7 one-cycle delayed clear after completion
    wr(ctl(1, 1, 1, 0, 0, 0, 0));
    chk("R7 enable set", ch_en_o[1], 1'b1);
    @(negedge clk);
    eng_done[1] = 1'b1;
    @(negedge clk);
    eng_done[1] = 1'b0;
    chk("R7 still set after first edge", ch_en_o[1], 1'b1);
    @(negedge clk);
    chk("R7 cleared after second edge", ch_en_o[1], 1'b0);

    // R6 disable waits for drain acknowledge, then R5 resume
    wr(ctl(2, 1, 1, 0, 0, 0, 0));
    wr(ctl(2, 0, 0, 1, 1, 0, 0));
    wr(ctl(2, 0, 1, 0, 0, 0, 0));
    repeat (5) @(negedge clk);
    chk("R6 enable held without ack", ch_en_o[2], 1'b1);
    chk("R4 state active while suspended+enabled", ch_state_o[5:4], 2'd2);
    eng_susp_ack[2] = 1'b1;
    @(negedge clk);
    eng_susp_ack[2] = 1'b0;
    chk("R6 enable cleared after ack", ch_en_o[2], 1'b0);
    chk("R4 state suspended", ch_state_o[5:4], 2'd1);
    rd(r);
    chk("R6 readback after drain", r, word_of(2, 0, 1, 0));
    wr(ctl(2, 0, 0, 0, 1, 0, 0));
    chk("R5 resume to idle", ch_state_o[5:4], 2'd0);

    // R8 abort ignored when idle, honoured when enabled
    wr(ctl(4, 0, 0, 0, 0, 1, 1));
    chk("R8 abort on idle ignored", ch_abort_o[4], 1'b0);
    wr(ctl(4, 1, 1, 0, 0, 0, 0));
    wr(ctl(4, 0, 0, 0, 0, 1, 1));
    chk("R8 abort output raised", ch_abort_o[4], 1'b1);
    rd(r);
    chk("R8 abort readback", r, word_of(4, 1, 0, 1));
    @(negedge clk);
    eng_abort_done[4] = 1'b1;
    @(negedge clk);
    eng_abort_done[4] = 1'b0;
    @(negedge clk);
    chk("R7 abort-complete clears", {ch_en_o[4], ch_abort_o[4]}, 2'b00);

    // R11 read in the same cycle as a write returns the old value
    @(negedge clk);
    bus_wr = 1'b1;
    bus_wdata = ctl(5, 1, 1, 0, 0, 0, 0);
    bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    bus_rd = 1'b0;
    bus_wdata = '0;
    chk("R11 read shows pre-write value", bus_rdata, 64'h0);
    chk("R11 write still applied", ch_en_o[5], 1'b1);
    finish_ch(5);

    // Sweep: every channel, four start states, all 64 field combinations (R1 R2 R3 R4 R9 R10)
    for (int n = 0; n < N; n++) begin
      for (int s = 0; s < 4; s++) begin
        for (int c = 0; c < 64; c++) begin
          bit e0, s0, ed, ew, sd, sw, ad, aw, ee, se, ae;
          logic [63:0] w, noise;
          e0 = s[0]; s0 = s[1];
          {aw, ad, sw, sd, ew, ed} = c[5:0];
          finish_ch(n);
          if (e0) wr(ctl(n, 1, 1, 0, 0, 0, 0));
          if (s0) wr(ctl(n, 0, 0, 1, 1, 0, 0));
          ee = e0; se = s0; ae = 1'b0;
          if (aw && ad && e0)  ae = 1'b1;
          else if (sw && sd)   se = 1'b1;
          else begin
            if (sw) se = 1'b0;
            if (ew && ed) ee = 1'b1;
          end
          noise = 64'h000000FF_00FF_00FF & ~word_of(n, 1, 1, 1);
          w = ctl(n, ed, ew, sd, sw, ad, aw) | noise;
          wr(w);
          rd(r);
          chk($sformatf("R1 R2 R3 R9 ch%0d start%0d combo%0d readback", n, s, c), r, word_of(n, ee, se, ae));
          chk($sformatf("R4 ch%0d start%0d combo%0d state", n, s, c),
              {62'd0, ch_state_o[2*n +: 2]}, {62'd0, ee ? 2'd2 : (se ? 2'd1 : 2'd0)});
          chk($sformatf("R10 ch%0d start%0d combo%0d outputs", n, s, c),
              {61'd0, ch_en_o[n], ch_susp_o[n], ch_abort_o[n]}, {61'd0, ee, se, ae});
        end
      end
      finish_ch(n);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule